// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the multi-cycle part of subroutine call and return for a small 32-bit core in which register 0 serves as the frame pointer and register 1 as the stack pointer. The decode stage starts a call by presenting the current program counter, the call target and the instruction form. The block then lays down a three-word frame below the incoming stack pointer. The top word is a static-chain slot, which is reserved and never written. Below it go the return address and the caller's frame pointer. When the frame is complete, the block hands back new stack-pointer, frame-pointer and program-counter values in a single update cycle.

A return unwinds from the frame pointer, not from the stack pointer. It reads the saved frame pointer and the return address out of the frame, and it sets the stack pointer just past the static-chain slot. The block performs exactly one memory transaction per state. Memory is treated as answering in the same cycle, with a fault line. A fault on any transaction stops the sequence with no register update, and the block reports an error pulse.

Top module: `frame_seq`

## Requirements
- R1: After reset, `busy`, `regUpdate`, `seqError`, `memWrEn` and `memRdEn` are all low.
- R2: The first cycle of a call writes the return address to SP-8. The return address is `curPc`+6 when `callAbsForm`=1 (the form that carries a 32-bit immediate target) and `curPc`+2 when `callAbsForm`=0.
- R3: The second cycle of a call writes the incoming FP to SP-12. The static-chain word at SP-4 is never written.
- R4: In the third cycle after a call starts, `regUpdate` is high for exactly one cycle with `spOut`=`fpOut`=SP-12 and `pcOut`=`callTarget`.
- R5: A return reads from FP in its first cycle and from FP+4 in its second. In the third cycle, `regUpdate` is high with `fpOut` equal to the word read from FP, `pcOut` equal to the word read from FP+4, and `spOut`=FP+12.
- R6: At most one memory transaction occurs per cycle. `memWrEn` and `memRdEn` are never high together.
- R7: When `memFault` is high during a transaction, the sequence aborts. In the next cycle `seqError` is high for one cycle and `busy` is low. No `regUpdate` follows, and no further transaction of that sequence is issued.
- R8: `busy` is high from the cycle after a start through the completion cycle. Start requests that arrive while `busy` is high are ignored.
- R9: When `startCall` and `startRet` arrive in the same idle cycle, the call is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCall | input | 1 | Begin a call sequence (sampled when idle) |
| startRet | input | 1 | Begin a return sequence (sampled when idle) |
| callAbsForm | input | 1 | 1: absolute-immediate call form, 0: register-target form |
| curPc | input | 32 | Address of the call instruction |
| callTarget | input | 32 | Address the call branches to |
| spIn | input | 32 | Current stack pointer |
| fpIn | input | 32 | Current frame pointer |
| memWrEn | output | 1 | Word write request |
| memWrAddr | output | 32 | Word write byte address |
| memWrData | output | 32 | Word write data |
| memRdEn | output | 1 | Word read request |
| memRdAddr | output | 32 | Word read byte address |
| memRdData | input | 32 | Read data, valid in the request cycle |
| memFault | input | 1 | Fault on the current transaction |
| busy | output | 1 | Sequence in progress |
| regUpdate | output | 1 | One-cycle strobe to load spOut, fpOut and pcOut |
| spOut | output | 32 | New stack pointer |
| fpOut | output | 32 | New frame pointer |
| pcOut | output | 32 | New program counter |
| seqError | output | 1 | One-cycle pulse after an aborted sequence |

## Verification
The hardest situation to reach from the ports is a fault on the second transaction of a sequence. By then the first transaction has already changed memory, yet no register may change. The stimulus table carries a fault selector that arms the bench memory's fault line on the address of either the first or the second transaction, for both calls and returns. The bench then checks three things: the error timing, the absence of an update, and, for calls, which frame words were actually written. Start requests arriving while the block is busy, and a call and a return requested together, are driven as directed cases.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_RA,
    ST_PUSH_FP,
    ST_POP_FP,
    ST_POP_RA,
    ST_COMMIT
  } seqState_t;

  typedef enum logic [1:0] {
    AD_RA_SLOT,
    AD_FP_SLOT,
    AD_FRAME_BASE,
    AD_FRAME_RA
  } addrSel_t;

  typedef struct packed {
    logic     latchCall;
    logic     latchRet;
    logic     wrEn;
    logic     rdEn;
    logic     capFp;
    logic     capPc;
    logic     commit;
    addrSel_t addrSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/frame_seq_dp.sv
module frame_seq_dp
  import frame_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int SHORT_LEN  = 2,
  parameter int LONG_LEN   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic              callAbsForm,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] callTarget,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] fpIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] fpOut,
  output logic [DATA_W-1:0] pcOut
);

  localparam logic [DATA_W-1:0] STEP      = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] RA_OFS    = DATA_W'(2 * WORD_BYTES);
  localparam logic [DATA_W-1:0] FRAME_SZ  = DATA_W'(3 * WORD_BYTES);
  localparam logic [DATA_W-1:0] SHORT_INC = DATA_W'(SHORT_LEN);
  localparam logic [DATA_W-1:0] LONG_INC  = DATA_W'(LONG_LEN);

  logic [DATA_W-1:0] baseSp, baseFp, targetQ, retAddrQ, savedFp, savedPc;
  logic              isRetQ;
  logic [DATA_W-1:0] newFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseSp   <= '0;
      baseFp   <= '0;
      targetQ  <= '0;
      retAddrQ <= '0;
      savedFp  <= '0;
      savedPc  <= '0;
      isRetQ   <= 1'b0;
    end else begin
      if (ctrl.latchCall) begin
        baseSp   <= spIn;
        baseFp   <= fpIn;
        targetQ  <= callTarget;
        retAddrQ <= curPc + (callAbsForm ? LONG_INC : SHORT_INC);
        isRetQ   <= 1'b0;
      end else if (ctrl.latchRet) begin
        baseFp <= fpIn;
        isRetQ <= 1'b1;
      end
      if (ctrl.capFp) savedFp <= memRdData;
      if (ctrl.capPc) savedPc <= memRdData;
    end
  end

  always_comb begin
    unique case (ctrl.addrSel)
      AD_RA_SLOT:    memAddr = baseSp - RA_OFS;
      AD_FP_SLOT:    memAddr = baseSp - FRAME_SZ;
      AD_FRAME_BASE: memAddr = baseFp;
      default:       memAddr = baseFp + STEP;
    endcase
  end

  assign memWrData = (ctrl.addrSel == AD_RA_SLOT) ? retAddrQ : baseFp;
  assign newFrame  = baseSp - FRAME_SZ;

  assign spOut = isRetQ ? baseFp + FRAME_SZ : newFrame;
  assign fpOut = isRetQ ? savedFp : newFrame;
  assign pcOut = isRetQ ? savedPc : targetQ;

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startCall,
  input  logic         startRet,
  input  logic         memFault,
  output ctrlStrobes_t ctrl,
  output logic         busy,
  output logic         seqError
);

  seqState_t stateQ, stateD;
  logic      abortNow;
  logic      errQ;

  always_comb begin
    stateD   = stateQ;
    abortNow = 1'b0;
    ctrl     = '{default: '0, addrSel: AD_RA_SLOT};
    unique case (stateQ)
      ST_IDLE: begin
        if (startCall) begin
          ctrl.latchCall = 1'b1;
          stateD = ST_PUSH_RA;
        end else if (startRet) begin
          ctrl.latchRet = 1'b1;
          stateD = ST_POP_FP;
        end
      end
      ST_PUSH_RA: begin
        ctrl.wrEn    = 1'b1;
        ctrl.addrSel = AD_RA_SLOT;
        abortNow     = memFault;
        stateD       = memFault ? ST_IDLE : ST_PUSH_FP;
      end
      ST_PUSH_FP: begin
        ctrl.wrEn    = 1'b1;
        ctrl.addrSel = AD_FP_SLOT;
        abortNow     = memFault;
        stateD       = memFault ? ST_IDLE : ST_COMMIT;
      end
      ST_POP_FP: begin
        ctrl.rdEn    = 1'b1;
        ctrl.addrSel = AD_FRAME_BASE;
        ctrl.capFp   = !memFault;
        abortNow     = memFault;
        stateD       = memFault ? ST_IDLE : ST_POP_RA;
      end
      ST_POP_RA: begin
        ctrl.rdEn    = 1'b1;
        ctrl.addrSel = AD_FRAME_RA;
        ctrl.capPc   = !memFault;
        abortNow     = memFault;
        stateD       = memFault ? ST_IDLE : ST_COMMIT;
      end
      ST_COMMIT: begin
        ctrl.commit = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= abortNow;
    end
  end

  assign busy     = (stateQ != ST_IDLE);
  assign seqError = errQ;

endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int SHORT_LEN  = 2,
  parameter int LONG_LEN   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCall,
  input  logic              startRet,
  input  logic              callAbsForm,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] callTarget,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] fpIn,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdEn,
  output logic [DATA_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memFault,
  output logic              busy,
  output logic              regUpdate,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] fpOut,
  output logic [DATA_W-1:0] pcOut,
  output logic              seqError
);

  ctrlStrobes_t      ctrl;
  logic [DATA_W-1:0] memAddr;

  frame_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startCall(startCall),
    .startRet (startRet),
    .memFault (memFault),
    .ctrl     (ctrl),
    .busy     (busy),
    .seqError (seqError)
  );

  frame_seq_dp #(
    .DATA_W    (DATA_W),
    .WORD_BYTES(WORD_BYTES),
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .callAbsForm(callAbsForm),
    .curPc      (curPc),
    .callTarget (callTarget),
    .spIn       (spIn),
    .fpIn       (fpIn),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .spOut      (spOut),
    .fpOut      (fpOut),
    .pcOut      (pcOut)
  );

  assign memWrEn   = ctrl.wrEn;
  assign memRdEn   = ctrl.rdEn;
  assign memWrAddr = memAddr;
  assign memRdAddr = memAddr;
  assign regUpdate = ctrl.commit;

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWrEn,
  input logic [DATA_W-1:0] memWrAddr,
  input logic              memRdEn,
  input logic [DATA_W-1:0] memRdAddr,
  input logic [DATA_W-1:0] memRdData,
  input logic              memFault,
  input logic              busy,
  input logic              regUpdate,
  input logic [DATA_W-1:0] spOut,
  input logic [DATA_W-1:0] fpOut,
  input logic [DATA_W-1:0] pcOut,
  input logic              seqError
);

  p_one_txn_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));

  p_busy_covers_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn || memRdEn || regUpdate) |-> busy);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((memWrEn || memRdEn) && memFault) |=> (seqError && !busy && !regUpdate));

  p_err_no_update_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(seqError && regUpdate));

  p_push_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memFault && !$past(memWrEn))
      |=> (memWrEn && memWrAddr == $past(memWrAddr) - DATA_W'(4)));

  p_call_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memFault && $past(memWrEn))
      |=> (regUpdate && spOut == $past(memWrAddr) && fpOut == spOut));

  p_ret_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !memFault && $past(memRdEn))
      |=> (regUpdate && spOut == $past(memRdAddr) + DATA_W'(8)
           && pcOut == $past(memRdData) && fpOut == $past(memRdData, 2)));

  p_update_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    regUpdate |=> !regUpdate);

endmodule

bind frame_seq frame_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/frame_seq_tb.sv
module frame_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic        isRet;
    logic        absForm;
    logic [1:0]  faultSel;   // 0 none, 1 first transaction, 2 second
    logic [31:0] pc;
    logic [31:0] target;
    logic [31:0] sp;
    logic [31:0] fp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 2'd0, 32'h0000_0100, 32'h0000_0400, 32'h0000_00C0, 32'h0000_00D0},
    '{1'b0, 1'b0, 2'd0, 32'h0000_0222, 32'h1234_5678, 32'h0000_0080, 32'h0000_0090},
    '{1'b1, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0050, 32'h0000_0060},
    '{1'b1, 1'b1, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0090, 32'h0000_00A4},
    '{1'b0, 1'b1, 2'd1, 32'h0000_0300, 32'h0000_0800, 32'h0000_00F0, 32'h0000_0044},
    '{1'b0, 1'b0, 2'd2, 32'h0000_0310, 32'h0000_0900, 32'h0000_00B0, 32'h0000_0048},
    '{1'b1, 1'b0, 2'd1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0060, 32'h0000_0070},
    '{1'b1, 1'b0, 2'd2, 32'h0000_0000, 32'h0000_0000, 32'h0000_0040, 32'h0000_0054}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startCall = 1'b0, startRet = 1'b0, callAbsForm = 1'b0;
  logic [31:0] curPc = '0, callTarget = '0, spIn = '0, fpIn = '0;
  logic        memWrEn, memRdEn, memFault, busy, regUpdate, seqError;
  logic [31:0] memWrAddr, memWrData, memRdAddr, memRdData, spOut, fpOut, pcOut;

  logic [31:0] mem [64];
  logic        faultOn = 1'b0;
  logic [31:0] faultAddr = '0;

  int nTests = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_seq dut_i (.*);

  assign memRdData = mem[memRdAddr[7:2]];
  assign memFault  = faultOn && ((memWrEn && memWrAddr == faultAddr) ||
                                 (memRdEn && memRdAddr == faultAddr));

  always @(posedge clk)
    if (memWrEn && !memFault) mem[memWrAddr[7:2]] <= memWrData;

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // results of the last run
  logic        gotUpd, gotErr, bothTxn;
  int          updCyc, errCyc;
  logic [31:0] rSp, rFp, rPc;

  task automatic runOp(input vec_t v, input logic alsoRet, input logic lateRet);
    @(negedge clk);
    callAbsForm = v.absForm;
    curPc = v.pc; callTarget = v.target; spIn = v.sp; fpIn = v.fp;
    startCall = !v.isRet;
    startRet  = v.isRet | alsoRet;
    gotUpd = 0; gotErr = 0; bothTxn = 0; updCyc = 0; errCyc = 0;
    @(negedge clk);
    startCall = 0; startRet = 0;
    for (int k = 1; k <= 8; k++) begin
      if (memWrEn && memRdEn) bothTxn = 1;
      if (k == 1 && lateRet) startRet = 1;
      if (k == 2) startRet = 0;
      if (regUpdate && !gotUpd) begin
        gotUpd = 1; updCyc = k; rSp = spOut; rFp = fpOut; rPc = pcOut;
      end
      if (seqError && !gotErr) begin
        gotErr = 1; errCyc = k;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_0000 | 32'(i);
    repeat (3) @(negedge clk);
    check(!busy && !regUpdate && !seqError && !memWrEn && !memRdEn,
          "R1 reset outputs", {27'b0, busy, regUpdate, seqError, memWrEn, memRdEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !regUpdate, "R1 idle after reset", {31'b0, busy}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v = VECS[i];
      logic [31:0] ra, sent, savedFp, savedPc, fAddr;
      ra = v.pc + (v.absForm ? 32'd6 : 32'd2);
      sent = 32'hA5A5_0000 | 32'(i);
      savedFp = 32'h0000_1000 + 32'(i * 16);
      savedPc = 32'h0000_2000 + 32'(i * 8);
      @(negedge clk);
      mem[(v.sp - 4) >> 2]  = sent;
      mem[(v.sp - 8) >> 2]  = sent + 1;
      mem[(v.sp - 12) >> 2] = sent + 2;
      if (v.isRet) begin
        mem[v.fp >> 2]       = savedFp;
        mem[(v.fp + 4) >> 2] = savedPc;
      end
      if (v.isRet) fAddr = (v.faultSel == 2'd1) ? v.fp : v.fp + 4;
      else         fAddr = (v.faultSel == 2'd1) ? v.sp - 8 : v.sp - 12;
      faultAddr = fAddr;
      faultOn = (v.faultSel != 2'd0);
      runOp(v, 1'b0, 1'b0);
      faultOn = 1'b0;
      check(!bothTxn, "R6 single transaction", {31'b0, bothTxn}, 32'h0);
      if (v.faultSel == 2'd0) begin
        check(gotUpd && updCyc == 3, "R4 R5 update in third cycle", 32'(updCyc), 32'd3);
        check(!gotErr, "R7 no error without fault", {31'b0, gotErr}, 32'h0);
        if (!v.isRet) begin
          check(mem[(v.sp - 8) >> 2] == ra, "R2 return address at SP-8",
                mem[(v.sp - 8) >> 2], ra);
          check(mem[(v.sp - 12) >> 2] == v.fp, "R3 old FP at SP-12",
                mem[(v.sp - 12) >> 2], v.fp);
          check(mem[(v.sp - 4) >> 2] == sent, "R3 static chain untouched",
                mem[(v.sp - 4) >> 2], sent);
          check(rSp == v.sp - 12, "R4 new SP", rSp, v.sp - 12);
          check(rFp == v.sp - 12, "R4 new FP", rFp, v.sp - 12);
          check(rPc == v.target, "R4 new PC", rPc, v.target);
        end else begin
          check(rFp == savedFp, "R5 restored FP", rFp, savedFp);
          check(rPc == savedPc, "R5 restored PC", rPc, savedPc);
          check(rSp == v.fp + 12, "R5 SP is FP+12", rSp, v.fp + 12);
        end
      end else begin
        check(gotErr && errCyc == 32'(v.faultSel) + 1, "R7 error pulse timing",
              32'(errCyc), 32'(v.faultSel) + 1);
        check(!gotUpd, "R7 no register update", {31'b0, gotUpd}, 32'h0);
        if (!v.isRet && v.faultSel == 2'd1)
          check(mem[(v.sp - 12) >> 2] == sent + 2, "R7 no push after fault",
                mem[(v.sp - 12) >> 2], sent + 2);
      end
      check(!busy, "R8 busy low after finish", {31'b0, busy}, 32'h0);
    end

    // R8: a return request during a call is ignored
    begin
      vec_t v = '{1'b0, 1'b1, 2'd0, 32'h40, 32'h7000, 32'hE0, 32'hC8};
      runOp(v, 1'b0, 1'b1);
      check(gotUpd && updCyc == 3 && rPc == 32'h7000, "R8 call unaffected by late start",
            rPc, 32'h7000);
      check(!busy && !memRdEn, "R8 late start left no sequence", {31'b0, busy}, 32'h0);
    end

    // R8: busy through the completion cycle
    begin
      int busyCnt = 0;
      @(negedge clk);
      curPc = 32'h10; callTarget = 32'h20; spIn = 32'hA0; fpIn = 32'hB0; startCall = 1;
      @(negedge clk);
      startCall = 0;
      for (int k = 0; k < 6; k++) begin
        if (busy) busyCnt++;
        @(negedge clk);
      end
      check(busyCnt == 3, "R8 busy cycle count", 32'(busyCnt), 32'd3);
    end

    // R9: call and return requested together
    begin
      @(negedge clk);
      curPc = 32'h50; callTarget = 32'h90; spIn = 32'hD0; fpIn = 32'h64;
      startCall = 1; startRet = 1;
      @(negedge clk);
      startCall = 0; startRet = 0;
      check(memWrEn && !memRdEn, "R9 call wins", {30'b0, memWrEn, memRdEn}, 32'h2);
      repeat (2) @(negedge clk);
      check(regUpdate && pcOut == 32'h90, "R9 call completed", pcOut, 32'h90);
      repeat (2) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule